// File: doc/BRIEF.md
# Per-Bit Change-of-State Interrupt Unit

This unit watches eight digital input lines and turns their transitions into interrupts and event counts. Each line first passes through a synchroniser clocked by the 125 MHz system clock. The unit then compares each line's newest sample with the one before it. For each line, software chooses whether a rising or a falling transition counts as the qualifying edge. A qualifying edge on a line with its interrupt enable set records a sticky change-of-state flag. Separately, a qualifying edge on a line with its count enable set advances that line's own 16-bit event counter.

A counter that rolls over from all ones to zero records a sticky wrap flag. The wrap flag takes part in the interrupt only when that line's wrap-interrupt enable is set. A single level interrupt output combines every recorded flag that is currently enabled. Software reaches all of this through a flat register port. Writes take effect on the clock edge and reads are combinational. Flags clear when software writes ones to them, and a counter can be preset by writing to it.

Top module: `cos_irq_unit`

## Requirements
- R1: After reset every register reads zero, every counter reads zero and `irq` is low.
- R2: The edge-select register at address 1 picks the qualifying edge per line: bit value 0 means rising and 1 means falling. A qualifying edge on a line whose bit is set in the interrupt-enable register (address 0) sets that line's bit in the change-of-state flag register (address 4). The input is sampled at the first clock edge after it changes. The flag and the counter become visible after the third clock edge.
- R3: A qualifying edge on a line whose interrupt-enable bit is 0 leaves its change-of-state flag at 0.
- R4: A transition in the direction not selected changes neither the flag nor the counter of that line.
- R5: Writing to address 4 clears the flag bits written as 1 and leaves those written as 0. If a clear and a new qualifying edge meet in the same cycle, the flag stays set. The wrap flags at address 5 clear the same way.
- R6: A line whose bit is set in the count-enable register (address 2) adds one to its counter on each qualifying edge, whatever its interrupt enable says. When the count-enable bit is 0, the counter holds its value.
- R7: A counted edge while the counter holds 0xFFFF wraps it to 0x0000 and sets that line's bit in the wrap flag register (address 5).
- R8: `irq` is high exactly when some line has a change-of-state flag together with its interrupt enable, or a wrap flag together with its bit in the wrap-enable register (address 3). A wrap flag whose enable is 0 keeps `irq` low.
- R9: Counter n is read at address 8+n. Writing there loads the written value. A load that meets a counted edge in the same cycle takes precedence over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz system clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Input lines, one per monitored bit |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 4 | Register address for both read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for `regAddr` |
| irq | output | 1 | Combined level interrupt |

## Verification
An input change driven between clock edges is captured at the first rising edge. It reaches the compare stage at the second edge and lands in the flags and counters at the third. The bench therefore waits three rising edges and samples on the following falling edge. It also confirms that nothing has moved after only two edges. Register writes take effect on the single edge they straddle, and reads are combinational, so reads are checked half a cycle after the address is set. To test the same-cycle races, a clear or a load is placed on the third edge after an input change, which is exactly the edge on which the flag or counter would otherwise update.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  localparam int LANES = 8;
  localparam int CNT_W = 16;
  localparam int CNT_BASE = 8;

  // configuration held by the control block
  typedef struct packed {
    logic [LANES-1:0] cosEn;
    logic [LANES-1:0] edgeFall;
    logic [LANES-1:0] cntEn;
    logic [LANES-1:0] wrapEn;
  } cfg_t;

  // single-cycle strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] cosClr;
    logic [LANES-1:0] wrapClr;
    logic [LANES-1:0] cntLoad;
    logic [CNT_W-1:0] loadValue;
  } strobe_t;
endpackage

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int ADDR_WIDTH = 4,
  parameter int DATA_WIDTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [ADDR_WIDTH-1:0]       regAddr,
  input  logic [DATA_WIDTH-1:0]       regWrData,
  input  logic [LANES-1:0]            cosStatus,
  input  logic [LANES-1:0]            wrapStatus,
  input  logic [LANES-1:0][CNT_W-1:0] counts,
  output cfg_t                        cfg,
  output strobe_t                     strobes,
  output logic [DATA_WIDTH-1:0]       regRdData
);
  localparam logic [ADDR_WIDTH-1:0] ADDR_COS_EN    = ADDR_WIDTH'(0);
  localparam logic [ADDR_WIDTH-1:0] ADDR_EDGE_SEL  = ADDR_WIDTH'(1);
  localparam logic [ADDR_WIDTH-1:0] ADDR_CNT_EN    = ADDR_WIDTH'(2);
  localparam logic [ADDR_WIDTH-1:0] ADDR_WRAP_EN   = ADDR_WIDTH'(3);
  localparam logic [ADDR_WIDTH-1:0] ADDR_COS_STAT  = ADDR_WIDTH'(4);
  localparam logic [ADDR_WIDTH-1:0] ADDR_WRAP_STAT = ADDR_WIDTH'(5);

  logic [LANES-1:0] wrLane;
  assign wrLane = regWrData[LANES-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_COS_EN:   cfg.cosEn    <= wrLane;
        ADDR_EDGE_SEL: cfg.edgeFall <= wrLane;
        ADDR_CNT_EN:   cfg.cntEn    <= wrLane;
        ADDR_WRAP_EN:  cfg.wrapEn   <= wrLane;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    strobes.loadValue = regWrData[CNT_W-1:0];
    if (regWrEn && regAddr == ADDR_COS_STAT)  strobes.cosClr  = wrLane;
    if (regWrEn && regAddr == ADDR_WRAP_STAT) strobes.wrapClr = wrLane;
    for (int i = 0; i < LANES; i++) begin
      strobes.cntLoad[i] = regWrEn && (regAddr == ADDR_WIDTH'(CNT_BASE + i));
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_COS_EN:    regRdData[LANES-1:0] = cfg.cosEn;
      ADDR_EDGE_SEL:  regRdData[LANES-1:0] = cfg.edgeFall;
      ADDR_CNT_EN:    regRdData[LANES-1:0] = cfg.cntEn;
      ADDR_WRAP_EN:   regRdData[LANES-1:0] = cfg.wrapEn;
      ADDR_COS_STAT:  regRdData[LANES-1:0] = cosStatus;
      ADDR_WRAP_STAT: regRdData[LANES-1:0] = wrapStatus;
      default: begin
        for (int i = 0; i < LANES; i++) begin
          if (regAddr == ADDR_WIDTH'(CNT_BASE + i)) regRdData[CNT_W-1:0] = counts[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/cos_irq_datapath.sv
module cos_irq_datapath
  import cos_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANES-1:0]            pinIn,
  input  cfg_t                        cfg,
  input  strobe_t                     strobes,
  output logic [LANES-1:0]            cosStatus,
  output logic [LANES-1:0]            wrapStatus,
  output logic [LANES-1:0][CNT_W-1:0] counts,
  output logic                        irq
);
  logic [SYNC_STAGES-1:0][LANES-1:0] syncPipe;
  logic [LANES-1:0] sampled, prevSample, qualEdge, wrapHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe   <= '0;
      prevSample <= '0;
    end else begin
      syncPipe   <= {syncPipe[SYNC_STAGES-2:0], pinIn};
      prevSample <= sampled;
    end
  end

  assign sampled = syncPipe[SYNC_STAGES-1];
  // a changed bit qualifies when its new level is the selected end level
  assign qualEdge = (sampled ^ prevSample) & (sampled ^ cfg.edgeFall);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic countStep;
    assign countStep  = qualEdge[g] && cfg.cntEn[g] && !strobes.cntLoad[g];
    assign wrapHit[g] = countStep && (counts[g] == '1);

    always_ff @(posedge clk) begin
      if (!rstN)                   counts[g] <= '0;
      else if (strobes.cntLoad[g]) counts[g] <= strobes.loadValue;
      else if (countStep)          counts[g] <= counts[g] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cosStatus  <= '0;
      wrapStatus <= '0;
    end else begin
      cosStatus  <= (cosStatus & ~strobes.cosClr) | (qualEdge & cfg.cosEn);
      wrapStatus <= (wrapStatus & ~strobes.wrapClr) | wrapHit;
    end
  end

  assign irq = |(cosStatus & cfg.cosEn) | |(wrapStatus & cfg.wrapEn);
endmodule

// File: rtl/cos_irq_unit.sv
module cos_irq_unit
  import cos_irq_pkg::*;
#(
  parameter int ADDR_WIDTH  = 4,
  parameter int DATA_WIDTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LANES-1:0]      pinIn,
  input  logic                  regWrEn,
  input  logic [ADDR_WIDTH-1:0] regAddr,
  input  logic [DATA_WIDTH-1:0] regWrData,
  output logic [DATA_WIDTH-1:0] regRdData,
  output logic                  irq
);
  cfg_t                        cfg;
  strobe_t                     strobes;
  logic [LANES-1:0]            cosStatus, wrapStatus;
  logic [LANES-1:0][CNT_W-1:0] counts;

  cos_irq_ctrl #(.ADDR_WIDTH(ADDR_WIDTH), .DATA_WIDTH(DATA_WIDTH)) ctrl_i (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData,
    .cosStatus, .wrapStatus, .counts,
    .cfg, .strobes, .regRdData
  );

  cos_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk, .rstN, .pinIn, .cfg, .strobes,
    .cosStatus, .wrapStatus, .counts, .irq
  );
endmodule

// File: rtl/cos_irq_checker.sv
module cos_irq_checker
  import cos_irq_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        regWrEn,
  input logic [LANES-1:0]            cosEn,
  input logic [LANES-1:0]            cntEn,
  input logic [LANES-1:0]            cosStatus,
  input logic [LANES-1:0]            wrapStatus,
  input logic [LANES-1:0][CNT_W-1:0] counts,
  input logic                        irq
);
  // R5: without a write, recorded flags never drop
  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((cosStatus & $past(cosStatus)) == $past(cosStatus)));

  // R3: new change-of-state flags only appear on enabled lines
  a_r3_disabled_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cosStatus & ~$past(cosStatus) & ~$past(cosEn)) == '0));

  // R8: no flag recorded means no interrupt
  a_r8_quiet_without_flags: assert property (@(posedge clk) disable iff (!rstN)
    (cosStatus == '0 && wrapStatus == '0) |-> !irq);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    // R7: a wrap flag only rises as the counter rolls from all ones to zero
    a_r7_wrap_on_rollover: assert property (@(posedge clk) disable iff (!rstN)
      $rose(wrapStatus[g]) |-> ($past(counts[g]) == '1 && counts[g] == '0));

    // R6: without a write a counter holds or steps by one
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
      !regWrEn |=> (counts[g] == $past(counts[g]) || counts[g] == $past(counts[g]) + CNT_W'(1)));

    // R6: a line with counting disabled keeps its count
    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!regWrEn && !cntEn[g]) |=> $stable(counts[g]));
  end
endmodule

bind cos_irq_unit cos_irq_checker chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
  .cosEn(cfg.cosEn), .cntEn(cfg.cntEn),
  .cosStatus(cosStatus), .wrapStatus(wrapStatus),
  .counts(counts), .irq(irq)
);

// File: tb/cos_irq_unit_tb.sv
module cos_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irq;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  cos_irq_unit dut_i (
    .clk, .rstN, .pinIn, .regWrEn, .regAddr, .regWrData, .regRdData, .irq
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectReg(string req, logic [3:0] addr, logic [15:0] exp);
    regAddr = addr;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic writeReg(logic [3:0] addr, logic [15:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // input change lands after the third rising edge
  task automatic setPins(logic [7:0] v);
    pinIn = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(int bitIdx);
    setPins(pinIn | (8'd1 << bitIdx));
    setPins(pinIn & ~(8'd1 << bitIdx));
  endtask

  task automatic testReset();
    for (int a = 0; a < 16; a++) expectReg("R1 register zero", 4'(a), 16'h0000);
    check("R1 irq low", {15'd0, irq}, 16'd1 ^ 16'd1);
  endtask

  task automatic testRising();
    writeReg(4'd0, 16'h0001);
    pinIn = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expectReg("R2 no flag before third edge", 4'd4, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    expectReg("R2 rising flag", 4'd4, 16'h0001);
    check("R8 irq with enabled flag", {15'd0, irq}, 16'd1);
    writeReg(4'd4, 16'h0001);
    expectReg("R5 cleared", 4'd4, 16'h0000);
    check("R8 irq drops after clear", {15'd0, irq}, 16'd0);
    setPins(8'h00);
    expectReg("R4 falling ignored on rising line", 4'd4, 16'h0000);
  endtask

  task automatic testFalling();
    writeReg(4'd1, 16'h0002);
    writeReg(4'd0, 16'h0003);
    setPins(8'h02);
    expectReg("R4 rising ignored on falling line", 4'd4, 16'h0000);
    setPins(8'h00);
    expectReg("R2 falling flag", 4'd4, 16'h0002);
    writeReg(4'd4, 16'h0000);
    expectReg("R5 zero write keeps flag", 4'd4, 16'h0002);
    writeReg(4'd4, 16'h0002);
  endtask

  task automatic testDisabled();
    pulse(2);
    expectReg("R3 disabled line no flag", 4'd4, 16'h0000);
    check("R3 irq stays low", {15'd0, irq}, 16'd0);
  endtask

  task automatic testClearRace();
    pulse(0);
    expectReg("R5 race setup flag", 4'd4, 16'h0001);
    pinIn = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd4; regWrData = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    expectReg("R5 edge beats clear", 4'd4, 16'h0001);
    setPins(8'h00);
    writeReg(4'd4, 16'h0001);
    expectReg("R5 clear after race", 4'd4, 16'h0000);
  endtask

  task automatic testCount();
    writeReg(4'd2, 16'h0008);
    for (int k = 0; k < 5; k++) pulse(3);
    expectReg("R6 five rising counted", 4'd11, 16'd5);
    expectReg("R6 count without cos flag", 4'd4, 16'h0000);
    writeReg(4'd2, 16'h0000);
    pulse(3);
    expectReg("R6 disabled count holds", 4'd11, 16'd5);
    writeReg(4'd1, 16'h000A);
    writeReg(4'd2, 16'h0008);
    pulse(3);
    expectReg("R6 falling counted once per pulse", 4'd11, 16'd6);
  endtask

  task automatic testWrap();
    writeReg(4'd12, 16'hFFFE);
    expectReg("R9 load readback", 4'd12, 16'hFFFE);
    writeReg(4'd2, 16'h0018);
    pulse(4);
    expectReg("R7 at all ones", 4'd12, 16'hFFFF);
    expectReg("R7 no wrap yet", 4'd5, 16'h0000);
    pulse(4);
    expectReg("R7 wrapped to zero", 4'd12, 16'h0000);
    expectReg("R7 wrap flag", 4'd5, 16'h0010);
    check("R8 masked wrap keeps irq low", {15'd0, irq}, 16'd0);
    writeReg(4'd3, 16'h0010);
    check("R8 enabled wrap raises irq", {15'd0, irq}, 16'd1);
    writeReg(4'd5, 16'h0010);
    expectReg("R5 wrap flag cleared", 4'd5, 16'h0000);
    check("R8 irq low after wrap clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic testLoadRace();
    pinIn = 8'h10;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd12; regWrData = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    expectReg("R9 load beats increment", 4'd12, 16'h1234);
    setPins(8'h00);
    pulse(4);
    expectReg("R9 counting resumes from load", 4'd12, 16'h1235);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRising();
    testFalling();
    testDisabled();
    testClearRace();
    testCount();
    testWrap();
    testLoadRace();
    finishRun();
  end
endmodule